// File: doc/BRIEF.md
# SPI Request/Response Handshake Sequencer

This block is an SPI master that carries out one synchronous request/response exchange with a peripheral. The peripheral paces every phase through its own ready line, `srdy`. A one-cycle `start` pulse launches an exchange. The block reads an outbound frame from a local byte buffer and pulls the select line low. It waits for the peripheral to drop `srdy`, then shifts the frame out. The length of the frame comes from the frame itself: byte 0 gives the number of payload bytes that follow a three-byte header.

With select still held low, the block waits for the peripheral to raise `srdy` again. It then clocks out three zero bytes as a poll and reads back the response header. The first header byte tells it how many more bytes to clock in. Every byte received during this phase is written into the buffer, starting at address 0. The buffer attaches through a plain memory port with a registered read, one cycle of latency, and a write strobe that is always accepted. This port has no valid/ready handshake and no back-pressure; the block owns the buffer while `busy` is high.

Each of the two handshake waits has its own cycle limit and its own abort code. The length of each wait is reported after a successful exchange.

Top module: `spi_sreq_ctrl`

## Requirements
- R1: After reset, `spi_ss_n`=1, `spi_sclk`=1, `busy`=0, `done`=0, `status`=0, and both wait-length outputs are 0.
- R2: A `start` pulse accepted while idle drives `spi_ss_n` low on the next clock edge. No SCLK edge occurs until `srdy`, after two synchronizer flops, is seen low.
- R3: The request is buffer bytes 0 to (byte0+2), sent in address order, MSB first, in SPI mode 3. SCLK idles high, MOSI changes on the falling edge, and MISO is sampled on the rising edge. SCLK runs at half the clock rate, so each low phase lasts exactly one cycle.
- R4: `spi_ss_n` stays low from the end of the request until the peripheral raises `srdy`.
- R5: The response is fetched by sending exactly three 0x00 bytes.
- R6: The first byte received, L, sets the total number of response bytes to L+3. Received byte k is written to buffer address k. Nothing is written beyond address L+2, and no buffer write happens outside the response phase.
- R7: On success, `spi_ss_n` rises only after the last response byte. In that same cycle, `done` pulses high for exactly one cycle with `status`=0.
- R8: Let k be the edge number, counted from the edge that lowered select, at which the raw `srdy` is first sampled low. If k+1 exceeds LO_LIMIT-1, the exchange aborts with `status`=1, releases select and clocks no byte.
- R9: Let j be the edge number, counted from the last request SCLK rise, at which the raw `srdy` is first sampled high. If j-1 exceeds HI_LIMIT-1, the exchange aborts with `status`=2, releases select and sends no poll byte.
- R10: After success, `wait_lo_cycles` equals k+1 and `wait_hi_cycles` equals j-1, with k and j as defined in R8 and R9.
- R11: An aborted exchange leaves both wait-length outputs at their previous values.
- R12: `start` is ignored while `busy` is high. No second exchange follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 select-to-low timeout, 2 response timeout |
| wait_lo_cycles | output | $clog2(LO_LIMIT) | Length of the first wait in the last successful exchange |
| wait_hi_cycles | output | $clog2(HI_LIMIT) | Length of the second wait in the last successful exchange |
| buf_addr | output | 9 | Buffer byte address |
| buf_re | output | 1 | Buffer read strobe; data is due one cycle later |
| buf_rdata | input | 8 | Buffer read data |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| srdy | input | 1 | Peripheral ready line, asynchronous |
| spi_ss_n | output | 1 | Active-low select |
| spi_sclk | output | 1 | SPI clock, idle high |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |

## Verification
Both wait lengths are checked at exact cycle offsets:
- The bench drops `srdy` at the d1-th falling clock edge after it sees select low. The reported first wait must then be d1+2.
- The bench raises `srdy` at the d2-th falling edge after the last request byte completes. The reported second wait must then be d2.

The sweep lands on each limit minus one, which must succeed, and one step past it, which must abort. The bench samples every result on falling edges. It waits for the single `done` pulse before comparing status, select and buffer contents. The peripheral model logs each byte on the rising SCLK edge that completes it, so request and poll bytes are compared in the order they went out.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_LO_TMO = 2'd1,
    RES_HI_TMO = 2'd2
  } sreq_result_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT_LO,
    PH_REQ_FETCH,
    PH_REQ_SEND,
    PH_REQ_SHIFT,
    PH_WAIT_HI,
    PH_POLL_SEND,
    PH_POLL_SHIFT
  } sreq_phase_e;

  localparam int unsigned HDR_BYTES = 3;
endpackage

// File: rtl/sreq_sync2.sv
module sreq_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      q      <= RESET_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sreq_wait_timer.sv
module sreq_wait_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW = $clog2(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [CW-1:0] count,
  output logic          expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (run) count <= count + 1'b1;
  end

  assign expired = (count == CW'(LIMIT - 1));
endmodule

// File: rtl/sreq_spi_shift.sv
module sreq_spi_shift #(
  parameter int unsigned BW = 8,
  localparam int unsigned BCW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [BW-1:0] tx,
  output logic          done,
  output logic [BW-1:0] rx,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  logic [BW-1:0]  sh_q;
  logic [BCW-1:0] bit_q;
  logic           act_q, high_q, smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      act_q  <= 1'b0;
      high_q <= 1'b0;
      smp_q  <= 1'b0;
      sclk   <= 1'b1;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (!act_q) begin
        if (go) begin
          act_q  <= 1'b1;
          sh_q   <= tx;
          bit_q  <= '0;
          high_q <= 1'b0;
          sclk   <= 1'b0;
        end
      end else if (!high_q) begin
        sclk   <= 1'b1;
        smp_q  <= miso;
        high_q <= 1'b1;
      end else begin
        high_q <= 1'b0;
        sh_q   <= {sh_q[BW-2:0], smp_q};
        if (bit_q == BCW'(BW - 1)) begin
          act_q <= 1'b0;
          done  <= 1'b1;
          rx    <= {sh_q[BW-2:0], smp_q};
        end else begin
          bit_q <= bit_q + 1'b1;
          sclk  <= 1'b0;
        end
      end
    end
  end

  assign mosi = sh_q[BW-1];
endmodule

// File: rtl/spi_sreq_ctrl.sv
module spi_sreq_ctrl
  import sreq_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned LO_LIMIT = 50000,
  parameter int unsigned HI_LIMIT = 200000,
  localparam int unsigned LO_W = $clog2(LO_LIMIT),
  localparam int unsigned HI_W = $clog2(HI_LIMIT),
  localparam int unsigned AW   = $clog2((1 << BYTE_W) + HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [LO_W-1:0]   wait_lo_cycles,
  output logic [HI_W-1:0]   wait_hi_cycles,
  output logic [AW-1:0]     buf_addr,
  output logic              buf_re,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_we,
  output logic [BYTE_W-1:0] buf_wdata,
  input  logic              srdy,
  output logic              spi_ss_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  sreq_phase_e       ph_q;
  logic [AW-1:0]     idx_q, tot_q, idx_nx;
  logic [LO_W-1:0]   lo_cap_q, lo_cnt;
  logic [HI_W-1:0]   hi_cap_q, hi_cnt;
  logic              srdy_s, lo_exp, hi_exp;
  logic              sh_go, sh_done;
  logic [BYTE_W-1:0] sh_tx, sh_rx;

  sreq_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(srdy), .q(srdy_s)
  );

  sreq_wait_timer #(.LIMIT(LO_LIMIT)) u_lo_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(ph_q != PH_WAIT_LO), .run(ph_q == PH_WAIT_LO),
    .count(lo_cnt), .expired(lo_exp)
  );

  sreq_wait_timer #(.LIMIT(HI_LIMIT)) u_hi_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(ph_q != PH_WAIT_HI), .run(ph_q == PH_WAIT_HI),
    .count(hi_cnt), .expired(hi_exp)
  );

  sreq_spi_shift #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx),
    .done(sh_done), .rx(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  assign idx_nx    = idx_q + 1'b1;
  assign buf_addr  = idx_q;
  assign buf_re    = (ph_q == PH_REQ_FETCH);
  assign buf_we    = (ph_q == PH_POLL_SHIFT) && sh_done;
  assign buf_wdata = sh_rx;
  assign sh_go     = (ph_q == PH_REQ_SEND) || (ph_q == PH_POLL_SEND);
  assign sh_tx     = (ph_q == PH_REQ_SEND) ? buf_rdata : '0;
  assign busy      = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q           <= PH_IDLE;
      idx_q          <= '0;
      tot_q          <= '0;
      lo_cap_q       <= '0;
      hi_cap_q       <= '0;
      wait_lo_cycles <= '0;
      wait_hi_cycles <= '0;
      spi_ss_n       <= 1'b1;
      done           <= 1'b0;
      status         <= RES_OK;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start) begin
            spi_ss_n <= 1'b0;
            idx_q    <= '0;
            ph_q     <= PH_WAIT_LO;
          end
        end
        PH_WAIT_LO: begin
          if (!srdy_s) begin
            lo_cap_q <= lo_cnt;
            ph_q     <= PH_REQ_FETCH;
          end else if (lo_exp) begin
            spi_ss_n <= 1'b1;
            done     <= 1'b1;
            status   <= RES_LO_TMO;
            ph_q     <= PH_IDLE;
          end
        end
        PH_REQ_FETCH: ph_q <= PH_REQ_SEND;
        PH_REQ_SEND: begin
          if (idx_q == '0) tot_q <= AW'(buf_rdata) + AW'(HDR_BYTES);
          ph_q <= PH_REQ_SHIFT;
        end
        PH_REQ_SHIFT: begin
          if (sh_done) begin
            if (idx_nx == tot_q) begin
              ph_q <= PH_WAIT_HI;
            end else begin
              idx_q <= idx_nx;
              ph_q  <= PH_REQ_FETCH;
            end
          end
        end
        PH_WAIT_HI: begin
          if (srdy_s) begin
            hi_cap_q <= hi_cnt;
            idx_q    <= '0;
            ph_q     <= PH_POLL_SEND;
          end else if (hi_exp) begin
            spi_ss_n <= 1'b1;
            done     <= 1'b1;
            status   <= RES_HI_TMO;
            ph_q     <= PH_IDLE;
          end
        end
        PH_POLL_SEND: ph_q <= PH_POLL_SHIFT;
        PH_POLL_SHIFT: begin
          if (sh_done) begin
            if (idx_q == '0) tot_q <= AW'(sh_rx) + AW'(HDR_BYTES);
            if ((idx_q != '0) && (idx_nx == tot_q)) begin
              spi_ss_n       <= 1'b1;
              done           <= 1'b1;
              status         <= RES_OK;
              wait_lo_cycles <= lo_cap_q;
              wait_hi_cycles <= hi_cap_q;
              ph_q           <= PH_IDLE;
            end else begin
              idx_q <= idx_nx;
              ph_q  <= PH_POLL_SEND;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sreq_ctrl_chk.sv
module spi_sreq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       buf_we,
  input logic       spi_ss_n,
  input logic       spi_sclk
);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> spi_sclk);

  assert_sclk_low_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |=> spi_sclk);

  assert_no_edge_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> !spi_ss_n);

  assert_write_in_exchange_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (busy && !spi_ss_n));

  assert_release_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_ss_n);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_status_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'd3));

  assert_launch_needs_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind spi_sreq_ctrl spi_sreq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .buf_we(buf_we), .spi_ss_n(spi_ss_n), .spi_sclk(spi_sclk)
);

// File: tb/spi_sreq_ctrl_tb.sv
`timescale 1ns/1ps
module spi_sreq_ctrl_tb;
  localparam int LO = 20;
  localparam int HI = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done;
  logic [1:0] status;
  logic [4:0] wait_lo_cycles, wait_hi_cycles;
  logic [8:0] buf_addr;
  logic       buf_re, buf_we;
  logic [7:0] buf_rdata = 8'h00;
  logic [7:0] buf_wdata;
  logic       srdy = 1'b1;
  logic       spi_ss_n, spi_sclk, spi_mosi, spi_miso;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  spi_sreq_ctrl #(.BYTE_W(8), .LO_LIMIT(LO), .HI_LIMIT(HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .wait_lo_cycles(wait_lo_cycles),
    .wait_hi_cycles(wait_hi_cycles), .buf_addr(buf_addr), .buf_re(buf_re),
    .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .srdy(srdy), .spi_ss_n(spi_ss_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // buffer memory, single writer process
  logic [7:0] mem [0:511];
  logic       h_we = 1'b0;
  logic [8:0] h_addr = '0;
  logic [7:0] h_data = '0;
  always @(posedge clk) begin
    if (buf_re) buf_rdata <= mem[buf_addr];
    if (buf_we) mem[buf_addr] <= buf_wdata;
    else if (h_we) mem[h_addr] <= h_data;
  end

  // peripheral model
  logic [7:0] s_rx [0:4095];
  logic [7:0] resp_mem [0:511];
  logic [7:0] s_sh = '0;
  logic [2:0] s_bitc = '0;
  int         s_n = 0;
  int         resp_base = 0;
  bit         resp_mode = 1'b0;
  logic [7:0] s_cur;

  always @(posedge spi_sclk) begin
    if (!spi_ss_n) begin
      if (s_bitc == 3'd7) begin
        s_rx[s_n % 4096] <= {s_sh[6:0], spi_mosi};
        s_n <= s_n + 1;
      end
      s_sh   <= {s_sh[6:0], spi_mosi};
      s_bitc <= s_bitc + 3'd1;
    end
  end

  always_comb s_cur = resp_mode ? resp_mem[(s_n - resp_base) % 512] : 8'h00;
  assign spi_miso = s_cur[3'd7 - s_bitc];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic host_wr(input int a, input int d);
    @(negedge clk);
    h_we = 1'b1; h_addr = 9'(a); h_data = 8'(d);
    @(negedge clk);
    h_we = 1'b0;
  endtask

  function automatic int req_pat(input int i, input int n);
    return (i * 37 + n * 5 + 1) & 255;
  endfunction

  function automatic int rsp_pat(input int i, input int l);
    return (i * 53 + l + 7) & 255;
  endfunction

  int prev_lo = 0;
  int prev_hi = 0;

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run_txn(input int n, input int rl, input int d1, input int d2, input bit extra);
    int base, rbase, bad, tail_before;
    bit lo_t, hi_t;
    lo_t = (d1 + 2 >= LO);
    hi_t = !lo_t && (d2 >= HI);
    host_wr(0, n);
    for (int i = 1; i <= n + 2; i++) host_wr(i, req_pat(i, n));
    resp_mem[0] = 8'(rl);
    for (int i = 1; i <= rl + 2; i++) resp_mem[i] = 8'(rsp_pat(i, rl));
    tail_before = mem[rl + 3];
    resp_mode = 1'b0;
    base = s_n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(spi_ss_n == 1'b0, "R2 select low after start", spi_ss_n, 0);
    repeat (d1) @(negedge clk);
    srdy = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    if (lo_t) begin
      wait_done();
      chk(status == 2'd1, "R8 status on first timeout", status, 1);
      chk(s_n == base, "R8 R2 no byte clocked", s_n - base, 0);
      chk(spi_ss_n == 1'b1, "R8 select released", spi_ss_n, 1);
      chk(wait_lo_cycles == prev_lo && wait_hi_cycles == prev_hi,
          "R11 counts kept after first timeout", wait_lo_cycles, prev_lo);
      srdy = 1'b1;
      @(negedge clk);
      return;
    end
    while (s_n < base + n + 3) @(negedge clk);
    chk(spi_ss_n == 1'b0, "R4 select held after request", spi_ss_n, 0);
    if (hi_t) begin
      wait_done();
      chk(status == 2'd2, "R9 status on response timeout", status, 2);
      chk(s_n == base + n + 3, "R9 no poll byte", s_n - base, n + 3);
      chk(spi_ss_n == 1'b1, "R9 select released", spi_ss_n, 1);
      chk(wait_lo_cycles == prev_lo && wait_hi_cycles == prev_hi,
          "R11 counts kept after response timeout", wait_hi_cycles, prev_hi);
      srdy = 1'b1;
      @(negedge clk);
      return;
    end
    repeat (d2) @(negedge clk);
    rbase = s_n;
    resp_base = rbase;
    resp_mode = 1'b1;
    srdy = 1'b1;
    wait_done();
    chk(status == 2'd0, "R7 success status", status, 0);
    chk(spi_ss_n == 1'b1, "R7 select released at done", spi_ss_n, 1);
    chk(int'(wait_lo_cycles) == d1 + 2, "R10 first wait length", wait_lo_cycles, d1 + 2);
    chk(int'(wait_hi_cycles) == d2, "R10 second wait length", wait_hi_cycles, d2);
    bad = -1;
    for (int i = 0; i <= n + 2; i++) begin
      int e;
      e = (i == 0) ? n : req_pat(i, n);
      if (bad < 0 && int'(s_rx[(base + i) % 4096]) != e) bad = i;
    end
    chk(bad < 0, "R3 request bytes in order", bad, -1);
    chk(rbase == base + n + 3, "R3 request length from byte 0", rbase - base, n + 3);
    bad = -1;
    for (int i = 0; i < 3; i++)
      if (bad < 0 && s_rx[(rbase + i) % 4096] != 8'h00) bad = i;
    chk(bad < 0, "R5 poll bytes zero", bad, -1);
    chk(s_n - rbase == rl + 3, "R6 response byte count", s_n - rbase, rl + 3);
    bad = -1;
    for (int i = 0; i <= rl + 2; i++)
      if (bad < 0 && mem[i] != resp_mem[i]) bad = i;
    chk(bad < 0, "R6 response stored from address 0", bad, -1);
    chk(int'(mem[rl + 3]) == tail_before, "R6 no write past response", mem[rl + 3], tail_before);
    prev_lo = d1 + 2;
    prev_hi = d2;
    @(negedge clk);
    resp_mode = 1'b0;
    chk(done == 1'b0, "R7 done lasts one cycle", done, 0);
    if (extra) begin
      int sn;
      sn = s_n;
      repeat (30) @(negedge clk);
      chk(busy == 1'b0 && spi_ss_n == 1'b1, "R12 start while busy ignored", busy, 0);
      chk(s_n == sn, "R12 no extra bytes", s_n - sn, 0);
    end
  endtask

  initial begin
    int ns [5];
    int rls [4];
    int d1s [3];
    int d2s [3];
    ns = '{0, 1, 2, 5, 20};
    rls = '{0, 1, 3, 17};
    d1s = '{0, 3, LO - 3};
    d2s = '{2, 6, HI - 1};
    for (int i = 0; i < 512; i++) host_wr_init(i);
    repeat (3) @(negedge clk);
    chk(spi_ss_n == 1'b1 && spi_sclk == 1'b1, "R1 reset lines idle", {spi_ss_n, spi_sclk}, 3);
    chk(busy == 1'b0 && done == 1'b0 && status == 2'd0, "R1 reset status", status, 0);
    chk(wait_lo_cycles == 0 && wait_hi_cycles == 0, "R1 reset wait counts", wait_lo_cycles, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && spi_ss_n == 1'b1, "R1 idle after reset release", busy, 0);
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++) begin
        int k;
        k = a * 4 + b;
        run_txn(ns[a], rls[b], d1s[k % 3], d2s[(k / 3) % 3], k == 5);
      end
    run_txn(2, 1, LO - 2, 4, 1'b0);
    run_txn(3, 2, 1, HI, 1'b0);
    run_txn(1, 4, 5, 3, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic host_wr_init(input int a);
    resp_mem[a] = 8'h00;
    s_rx[a] = 8'h00;
    if (a == 0) begin
      @(negedge clk);
    end
  endtask
endmodule